// File: doc/BRIEF.md
# Grouped Bypass Carry Adder

A purely combinational adder for two equal-width operands plus a carry-in. It produces the sum and the carry-out. The operand bits are cut into groups of equal size. Inside a group the carry ripples from bit to bit. Next to each group sits a bypass: when every bit of the group propagates, meaning the two operand bits differ, the carry entering the group is passed straight out of it. Otherwise the group's own ripple carry leaves the group. A group that does not propagate throughout either creates its outgoing carry or absorbs it, so the ripple result does not depend on the incoming carry.

An optional second bypass level gathers consecutive groups into sets. A set whose groups all propagate hands its incoming carry directly to the next set. With the bypass, a carry created in the lowest bit ripples through the first group, jumps over the middle groups, and ripples again only in the last group.

The widths are parameters, checked while the design is elaborated. By default the adder is 16 bits wide, with four groups of 4 bits and the second level spanning pairs of groups.

Top module: `carry_skip_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_o} equals op_a + op_b + carry_in, computed as unsigned numbers one bit wider than the operands.
- R2: When op_a and op_b differ in every bit of a group, that group's outgoing carry equals its incoming carry.
- R3: When some bit of a group has equal operand bits, the group's outgoing carry equals the carry out of that group's slice sum with a zero carry-in, whatever the incoming carry is.
- R4: When op_a is the bitwise inverse of op_b, carry_out equals carry_in, and sum_o is all ones for carry_in 0 and all zeros for carry_in 1.
- R5: With the second level enabled, a set whose groups all propagate passes its incoming carry straight to its outgoing carry.
- R6: A carry created in bit 0 (both operand bits 1), with every higher bit propagating, gives sum_o all zeros and carry_out 1.
- R7: WIDTH must be a whole multiple of GROUP_BITS. With the second level on, the group count must be a whole multiple of SET_GROUPS. Any other setting stops elaboration. The defaults are WIDTH 16, GROUP_BITS 4, SET_GROUPS 2, second level on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Two functions can act on the same carry at once: the ripple inside a group and the bypass around it, and, one level up, the group bypass and the set bypass. The bench provokes the overlap with operands that make whole groups or whole sets propagate while a carry is created just below them, and with operands that create a carry in bit 0 beneath an all-propagate span. A behavioural integer sum judges every case. The same reference judges an exhaustive sweep of a 6-bit copy that uses three groups of two bits under one set, and a random sweep of the default 16-bit copy.

// File: rtl/csa_pkg.sv
package csa_pkg;

   typedef struct packed {
      logic gen;
      logic prp;
   } pg_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/csa_pg_cell.sv
module csa_pg_cell
   import csa_pkg::*;
(
   input  logic a_bit,
   input  logic b_bit,
   output pg_t  pg
);
   always_comb begin
      pg.gen = a_bit & b_bit;
      pg.prp = a_bit ^ b_bit;
   end
endmodule

// File: rtl/csa_group.sv
module csa_group
   import csa_pkg::*;
#(
   parameter int unsigned GROUP_BITS = 4
) (
   input  logic [GROUP_BITS-1:0] a_slice,
   input  logic [GROUP_BITS-1:0] b_slice,
   input  logic                  grp_cin,
   output logic [GROUP_BITS-1:0] grp_sum,
   output logic                  grp_cout,
   output logic                  grp_prop
);
   pg_t  [GROUP_BITS-1:0] pg_v;
   logic [GROUP_BITS:0]   rip_c;
   logic [GROUP_BITS-1:0] prp_v;

   assign rip_c[0] = grp_cin;

   for (genvar i = 0; i < GROUP_BITS; i++) begin : g_bit
      csa_pg_cell pg_i (
         .a_bit (a_slice[i]),
         .b_bit (b_slice[i]),
         .pg    (pg_v[i])
      );
      assign prp_v[i]     = pg_v[i].prp;
      assign rip_c[i+1]   = pg_v[i].gen | (pg_v[i].prp & rip_c[i]);
      assign grp_sum[i]   = pg_v[i].prp ^ rip_c[i];
   end

   assign grp_prop = &prp_v;
   assign grp_cout = grp_prop ? grp_cin : rip_c[GROUP_BITS];
endmodule

// File: rtl/csa_skip_set.sv
module csa_skip_set
   import csa_pkg::*;
#(
   parameter int unsigned GROUP_BITS = 4,
   parameter int unsigned SET_GROUPS = 2,
   localparam int unsigned SET_BITS  = GROUP_BITS * SET_GROUPS
) (
   input  logic [SET_BITS-1:0]   a_set,
   input  logic [SET_BITS-1:0]   b_set,
   input  logic                  set_cin,
   output logic [SET_BITS-1:0]   set_sum,
   output logic                  set_cout,
   output logic                  set_prop,
   output logic [SET_GROUPS-1:0] g_cin,
   output logic [SET_GROUPS-1:0] g_cout,
   output logic [SET_GROUPS-1:0] g_prop
);
   assign g_cin[0] = set_cin;

   for (genvar k = 0; k < SET_GROUPS; k++) begin : g_grp
      csa_group #(.GROUP_BITS(GROUP_BITS)) grp_i (
         .a_slice  (a_set[k*GROUP_BITS +: GROUP_BITS]),
         .b_slice  (b_set[k*GROUP_BITS +: GROUP_BITS]),
         .grp_cin  (g_cin[k]),
         .grp_sum  (set_sum[k*GROUP_BITS +: GROUP_BITS]),
         .grp_cout (g_cout[k]),
         .grp_prop (g_prop[k])
      );
      if (k + 1 < SET_GROUPS) begin : g_link
         assign g_cin[k+1] = g_cout[k];
      end
   end

   assign set_prop = &g_prop;
   assign set_cout = set_prop ? set_cin : g_cout[SET_GROUPS-1];
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder
   import csa_pkg::*;
#(
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned GROUP_BITS = 4,
   parameter int unsigned SET_GROUPS = 2,
   parameter bit          USE_L2     = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_out
);
   localparam int unsigned NGROUPS = ceil_div(WIDTH, GROUP_BITS);
   localparam int unsigned NSETS   = USE_L2 ? ceil_div(NGROUPS, SET_GROUPS) : 1;

   // R7: configuration legality at elaboration
   if (WIDTH == 0 || GROUP_BITS == 0 || (WIDTH % GROUP_BITS) != 0) begin : g_bad_width
      $error("carry_skip_adder: WIDTH must be a nonzero multiple of GROUP_BITS");
   end
   if (USE_L2 && (SET_GROUPS == 0 || (NGROUPS % SET_GROUPS) != 0)) begin : g_bad_set
      $error("carry_skip_adder: group count must be a multiple of SET_GROUPS");
   end

   logic [NGROUPS-1:0] grp_cin;
   logic [NGROUPS-1:0] grp_cout;
   logic [NGROUPS-1:0] grp_prop;
   logic [NSETS-1:0]   set_cin;
   logic [NSETS-1:0]   set_cout;
   logic [NSETS-1:0]   set_prop;

   if (USE_L2) begin : g_two_level
      localparam int unsigned SET_BITS = GROUP_BITS * SET_GROUPS;
      assign set_cin[0] = carry_in;
      for (genvar s = 0; s < NSETS; s++) begin : g_set
         csa_skip_set #(.GROUP_BITS(GROUP_BITS), .SET_GROUPS(SET_GROUPS)) set_i (
            .a_set    (op_a[s*SET_BITS +: SET_BITS]),
            .b_set    (op_b[s*SET_BITS +: SET_BITS]),
            .set_cin  (set_cin[s]),
            .set_sum  (sum_o[s*SET_BITS +: SET_BITS]),
            .set_cout (set_cout[s]),
            .set_prop (set_prop[s]),
            .g_cin    (grp_cin[s*SET_GROUPS +: SET_GROUPS]),
            .g_cout   (grp_cout[s*SET_GROUPS +: SET_GROUPS]),
            .g_prop   (grp_prop[s*SET_GROUPS +: SET_GROUPS])
         );
         if (s + 1 < NSETS) begin : g_link
            assign set_cin[s+1] = set_cout[s];
         end
      end
      assign carry_out = set_cout[NSETS-1];
   end else begin : g_one_level
      assign grp_cin[0] = carry_in;
      for (genvar k = 0; k < NGROUPS; k++) begin : g_grp
         csa_group #(.GROUP_BITS(GROUP_BITS)) grp_i (
            .a_slice  (op_a[k*GROUP_BITS +: GROUP_BITS]),
            .b_slice  (op_b[k*GROUP_BITS +: GROUP_BITS]),
            .grp_cin  (grp_cin[k]),
            .grp_sum  (sum_o[k*GROUP_BITS +: GROUP_BITS]),
            .grp_cout (grp_cout[k]),
            .grp_prop (grp_prop[k])
         );
         if (k + 1 < NGROUPS) begin : g_link
            assign grp_cin[k+1] = grp_cout[k];
         end
      end
      assign set_cin[0]  = carry_in;
      assign set_prop[0] = &grp_prop;
      assign set_cout[0] = grp_cout[NGROUPS-1];
      assign carry_out   = grp_cout[NGROUPS-1];
   end
endmodule

// File: rtl/carry_skip_adder_chk.sv
module carry_skip_adder_chk #(
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned GROUP_BITS = 4,
   parameter int unsigned NGROUPS    = 4,
   parameter int unsigned NSETS      = 2
) (
   input logic [WIDTH-1:0]   op_a,
   input logic [WIDTH-1:0]   op_b,
   input logic               carry_in,
   input logic [WIDTH-1:0]   sum_o,
   input logic               carry_out,
   input logic [NGROUPS-1:0] grp_cin,
   input logic [NGROUPS-1:0] grp_cout,
   input logic [NGROUPS-1:0] grp_prop,
   input logic [NSETS-1:0]   set_cin,
   input logic [NSETS-1:0]   set_cout,
   input logic [NSETS-1:0]   set_prop
);
   logic [WIDTH:0] arith;
   assign arith = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

   always_comb begin
      assert_sum_R1: assert ({carry_out, sum_o} == arith)
         else $error("R1 sum mismatch");
      if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
         assert_full_prop_R4: assert (carry_out == carry_in && sum_o == {WIDTH{~carry_in}})
            else $error("R4 all-propagate mismatch");
      end
   end

   always_comb begin
      for (int k = 0; k < NGROUPS; k++) begin
         logic [GROUP_BITS:0] slice_sum;
         slice_sum = {1'b0, op_a[k*GROUP_BITS +: GROUP_BITS]}
                   + {1'b0, op_b[k*GROUP_BITS +: GROUP_BITS]};
         if (grp_prop[k]) begin
            assert_group_bypass_R2: assert (grp_cout[k] == grp_cin[k])
               else $error("R2 group bypass mismatch");
         end else begin
            assert_group_local_R3: assert (grp_cout[k] == slice_sum[GROUP_BITS])
               else $error("R3 group local carry mismatch");
         end
      end
   end

   always_comb begin
      for (int s = 0; s < NSETS; s++) begin
         if (set_prop[s]) begin
            assert_set_bypass_R5: assert (set_cout[s] == set_cin[s])
               else $error("R5 set bypass mismatch");
         end
      end
   end
endmodule

bind carry_skip_adder carry_skip_adder_chk #(
   .WIDTH      (WIDTH),
   .GROUP_BITS (GROUP_BITS),
   .NGROUPS    (NGROUPS),
   .NSETS      (NSETS)
) chk_i (
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sum_o     (sum_o),
   .carry_out (carry_out),
   .grp_cin   (grp_cin),
   .grp_cout  (grp_cout),
   .grp_prop  (grp_prop),
   .set_cin   (set_cin),
   .set_cout  (set_cout),
   .set_prop  (set_prop)
);

// File: tb/carry_skip_adder_tb_top.sv
`timescale 1ns/1ps
module carry_skip_adder_tb_top;
   localparam int W  = 16;
   localparam int WS = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [W-1:0]  a, b, s;
   logic          ci, co;
   logic [WS-1:0] as, bs, ss;
   logic          cis, cos;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   carry_skip_adder dut_i (
      .op_a(a), .op_b(b), .carry_in(ci), .sum_o(s), .carry_out(co)
   );

   carry_skip_adder #(.WIDTH(WS), .GROUP_BITS(2), .SET_GROUPS(3), .USE_L2(1'b1)) small_i (
      .op_a(as), .op_b(bs), .carry_in(cis), .sum_o(ss), .carry_out(cos)
   );

   task automatic chk_big(input logic [W-1:0] xa, input logic [W-1:0] xb,
                          input logic xc, input string tag);
      int unsigned ref_v;
      @(posedge clk);
      a <= xa; b <= xb; ci <= xc;
      @(negedge clk);
      ref_v = int'(xa) + int'(xb) + int'(xc);
      checks++;
      if ({co, s} !== ref_v[W:0]) begin
         errors++;
         $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h",
                  tag, xa, xb, xc, {co, s}, ref_v[W:0]);
      end
   endtask

   task automatic chk_small(input logic [WS-1:0] xa, input logic [WS-1:0] xb,
                            input logic xc);
      int unsigned ref_v;
      @(posedge clk);
      as <= xa; bs <= xb; cis <= xc;
      @(negedge clk);
      ref_v = int'(xa) + int'(xb) + int'(xc);
      checks++;
      if ({cos, ss} !== ref_v[WS:0]) begin
         errors++;
         $display("FAIL R1 small a=%h b=%h ci=%0d actual=%h expected=%h",
                  xa, xb, xc, {cos, ss}, ref_v[WS:0]);
      end
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; ci = 1'b0;
      as = '0; bs = '0; cis = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if ({co, s} !== '0) begin
         errors++;
         $display("FAIL R1 reset-time zero actual=%h expected=0", {co, s});
      end
      rst = 1'b0;

      // R7: default width
      checks++;
      if ($bits(s) != 16) begin
         errors++;
         $display("FAIL R7 width actual=%0d expected=16", $bits(s));
      end

      // R2: carry made in group 0, groups 1 bypass
      chk_big(16'h00F1, 16'h000F, 1'b0, "R2 group bypass");
      chk_big(16'h0F0F, 16'h00F1, 1'b0, "R2 bypass groups 1");
      // R3: non-propagating groups
      chk_big(16'h0011, 16'h0001, 1'b1, "R3 local carry");
      chk_big(16'h8888, 16'h8888, 1'b1, "R3 generate each group");
      chk_big(16'h0000, 16'h0000, 1'b1, "R3 kill everywhere");
      // R4: full propagate
      chk_big(16'hA5C3, 16'h5A3C, 1'b0, "R4 full prop ci0");
      chk_big(16'hA5C3, 16'h5A3C, 1'b1, "R4 full prop ci1");
      // R5: set 0 bypass, carry in from port
      chk_big(16'h00F0, 16'h000F, 1'b1, "R5 set bypass low");
      chk_big(16'hFF01, 16'h0001, 1'b0, "R5 set bypass high");
      // R6: worst case path
      chk_big(16'hFFFF, 16'h0001, 1'b0, "R6 worst path");
      chk_big(16'h0001, 16'hFFFF, 1'b0, "R6 worst path swapped");
      chk_big(16'hFFFF, 16'hFFFF, 1'b1, "R1 max operands");

      // R1: random sweep
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = (n % 3 == 0) ? ~ra ^ W'(1 << (n % W)) : W'($urandom);
         chk_big(ra, rb, 1'($urandom), "R1 random");
      end

      // R1: exhaustive small variant
      for (int x = 0; x < (1 << WS); x++) begin
         for (int y = 0; y < (1 << WS); y++) begin
            for (int c = 0; c < 2; c++) begin
               chk_small(WS'(x), WS'(y), 1'(c));
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule